// File: doc/BRIEF.md
# Directory Home-Node Coherence Controller

This block is the home side of a directory coherence scheme for a machine of four to eight nodes, each with a private cache. For every memory block homed here it keeps a three-valued block state and a sharer bit vector, together with the block's backing data word. Caches send it read misses, write misses and write-backs of owned blocks. It answers with invalidations, fetch or fetch-and-invalidate demands to the current owner, and a data reply to the requester. All coherence decisions are made in this one place, so no broadcast is needed.

Requests are served one at a time. Once a miss is accepted, the request channel stays closed until every outgoing message for that miss has been handed off, including the owner's returned block when one was demanded, and the final reply has gone out. Outgoing messages leave one per handshake on a single valid/ready channel. The owner's data comes back on a separate valid/ready response channel. A combinational probe port exposes the state, the sharer vector and the data of any one block for system-level inspection.

Top module: `dir_home_ctrl`

## Requirements
- R1: After reset every block is Uncached (state code 0) with an all-zero sharer vector and zero data, `req_ready` is high and `out_valid` is low.
- R2: The codes are as follows. Request kinds: 0 is read miss, 1 is write miss, 2 is write-back. Outgoing kinds: 0 is invalidate, 1 is fetch, 2 is fetch-and-invalidate, 3 is data reply. Block states: 0 is Uncached, 1 is Shared, 2 is Exclusive. Sharer bit i stands for node i.
- R3: In the Uncached state, a read miss from node P is answered with the stored data, and the block becomes Shared with sharers {P}. A write miss is answered with the stored data, and the block becomes Exclusive with sharers {P}.
- R4: In the Shared state, a read miss from P adds P to the sharers and is answered with the stored data.
- R5: In the Shared state, a write miss from P first sends one invalidate to each sharer other than P, in ascending node order. It then replies with the stored data and leaves the block Exclusive with sharers {P}. If P is the only sharer, only the reply is sent.
- R6: In the Exclusive state, a read miss from a node other than the owner sends a fetch to the owner and waits for the response. The returned data is written to storage and forwarded in the reply, and the block becomes Shared with sharers {owner, P}.
- R7: In the Exclusive state, a write miss from a node other than the owner sends a fetch-and-invalidate to the owner. The returned data is forwarded in the reply and is not written to storage. The block stays Exclusive with sharers {P}.
- R8: A write-back from the owner of an Exclusive block writes its data to storage, leaves the block Uncached with no sharers, and sends no message. A write-back from any other node, or to a block that is not Exclusive, changes nothing.
- R9: `req_ready` stays low from the acceptance of a miss until its reply has been handed off. While `out_valid` is high and `out_ready` is low, the outgoing kind, node, address and data hold steady.
- R10: An Exclusive block always has exactly one sharer bit set, a Shared block at least one, and an Uncached block none.
- R11: The requester is never the target of an invalidate, fetch or fetch-and-invalidate. A miss from the owner of an Exclusive block is answered with the stored data, and the state and sharers stay unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Incoming request present |
| req_ready | output | 1 | Controller can accept a request |
| req_kind | input | 2 | Request kind code |
| req_node | input | NID_W | Sending node |
| req_addr | input | ADDR_W | Block address |
| req_data | input | DATA_W | Data carried by a write-back |
| out_valid | output | 1 | Outgoing message present |
| out_ready | input | 1 | Network takes the outgoing message |
| out_kind | output | 2 | Outgoing message kind code |
| out_node | output | NID_W | Destination node |
| out_addr | output | ADDR_W | Block address of the message |
| out_data | output | DATA_W | Reply data |
| rsp_valid | input | 1 | Owner's returned block present |
| rsp_ready | output | 1 | Controller waits for the owner's block |
| rsp_data | input | DATA_W | Owner's returned block |
| probe_addr | input | ADDR_W | Block to inspect |
| probe_state | output | 2 | State code of the inspected block |
| probe_sharers | output | NODES | Sharer vector of the inspected block |
| probe_data | output | DATA_W | Stored data of the inspected block |

## Verification
On every cycle, the bound checker enforces these properties: a miss in flight blocks new requests, outgoing messages are held steady under backpressure, no demand ever targets the requester, the owner's data is not awaited while a message is pending, and the block being probed keeps a sharer vector that fits its state. The bench's scenarios are needed for the rest: the actual transitions, the ascending order of invalidations, which data goes to storage and which is only forwarded, and the silent discarding of stray write-backs. A reference model predicts every message and the probed state after each transaction, both for a directed table and for a long pseudo-random run with backpressure.

// File: rtl/dir_pkg.sv
package dir_pkg;
   typedef enum logic [1:0] {
      BLK_UNC = 2'd0,
      BLK_SHR = 2'd1,
      BLK_EXC = 2'd2
   } blk_state_t;

   localparam logic [1:0] RQ_READ  = 2'd0;
   localparam logic [1:0] RQ_WRITE = 2'd1;
   localparam logic [1:0] RQ_WBACK = 2'd2;

   localparam logic [1:0] MS_INVAL = 2'd0;
   localparam logic [1:0] MS_FETCH = 2'd1;
   localparam logic [1:0] MS_FINV  = 2'd2;
   localparam logic [1:0] MS_REPLY = 2'd3;
endpackage

// File: rtl/dir_first_set.sv
module dir_first_set #(
   parameter int N = 4,
   localparam int W = (N > 1) ? $clog2(N) : 1
) (
   input  logic [N-1:0] mask,
   output logic         any,
   output logic [W-1:0] idx
);
   always_comb begin
      idx = '0;
      for (int i = N - 1; i >= 0; i--) begin
         if (mask[i]) idx = W'(i);
      end
      any = |mask;
   end
endmodule

// File: rtl/dir_store.sv
module dir_store
   import dir_pkg::*;
#(
   parameter int NODES  = 4,
   parameter int ADDR_W = 4,
   parameter int DATA_W = 16,
   localparam int BLOCKS = 1 << ADDR_W,
   localparam int SW     = 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [ADDR_W-1:0] ra_addr,
   output blk_state_t        ra_state,
   output logic [NODES-1:0]  ra_shr,
   output logic [DATA_W-1:0] ra_data,
   input  logic [ADDR_W-1:0] rb_addr,
   output blk_state_t        rb_state,
   output logic [NODES-1:0]  rb_shr,
   output logic [DATA_W-1:0] rb_data,
   input  logic              dir_we,
   input  logic [ADDR_W-1:0] dir_waddr,
   input  blk_state_t        dir_wstate,
   input  logic [NODES-1:0]  dir_wshr,
   input  logic              mem_we,
   input  logic [ADDR_W-1:0] mem_waddr,
   input  logic [DATA_W-1:0] mem_wdata
);
   logic [BLOCKS*SW-1:0]     st_flat;
   logic [BLOCKS*NODES-1:0]  sh_flat;
   logic [BLOCKS*DATA_W-1:0] dt_flat;

   for (genvar g = 0; g < BLOCKS; g++) begin : g_blk
      blk_state_t        st_q;
      logic [NODES-1:0]  sh_q;
      logic [DATA_W-1:0] dt_q;

      always_ff @(posedge clk) begin
         if (!rst_n) begin
            st_q <= BLK_UNC;
            sh_q <= '0;
            dt_q <= '0;
         end else begin
            if (dir_we && (dir_waddr == ADDR_W'(g))) begin
               st_q <= dir_wstate;
               sh_q <= dir_wshr;
            end
            if (mem_we && (mem_waddr == ADDR_W'(g))) dt_q <= mem_wdata;
         end
      end

      assign st_flat[g*SW +: SW]         = st_q;
      assign sh_flat[g*NODES +: NODES]   = sh_q;
      assign dt_flat[g*DATA_W +: DATA_W] = dt_q;
   end

   always_comb begin
      ra_state = blk_state_t'(st_flat[SW*int'(ra_addr) +: SW]);
      ra_shr   = sh_flat[NODES*int'(ra_addr) +: NODES];
      ra_data  = dt_flat[DATA_W*int'(ra_addr) +: DATA_W];
      rb_state = blk_state_t'(st_flat[SW*int'(rb_addr) +: SW]);
      rb_shr   = sh_flat[NODES*int'(rb_addr) +: NODES];
      rb_data  = dt_flat[DATA_W*int'(rb_addr) +: DATA_W];
   end
endmodule

// File: rtl/dir_engine.sv
module dir_engine
   import dir_pkg::*;
#(
   parameter int NODES  = 4,
   parameter int ADDR_W = 4,
   parameter int DATA_W = 16,
   localparam int NID_W = $clog2(NODES)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              req_valid,
   output logic              req_ready,
   input  logic [1:0]        req_kind,
   input  logic [NID_W-1:0]  req_node,
   input  logic [ADDR_W-1:0] req_addr,
   input  logic [DATA_W-1:0] req_data,
   output logic              out_valid,
   input  logic              out_ready,
   output logic [1:0]        out_kind,
   output logic [NID_W-1:0]  out_node,
   output logic [ADDR_W-1:0] out_addr,
   output logic [DATA_W-1:0] out_data,
   input  logic              rsp_valid,
   output logic              rsp_ready,
   input  logic [DATA_W-1:0] rsp_data,
   input  blk_state_t        lk_state,
   input  logic [NODES-1:0]  lk_shr,
   input  logic [DATA_W-1:0] lk_data,
   output logic              dir_we,
   output logic [ADDR_W-1:0] dir_waddr,
   output blk_state_t        dir_wstate,
   output logic [NODES-1:0]  dir_wshr,
   output logic              mem_we,
   output logic [ADDR_W-1:0] mem_waddr,
   output logic [DATA_W-1:0] mem_wdata,
   output logic [NID_W-1:0]  busy_node
);
   typedef enum logic [2:0] {
      ST_IDLE, ST_INV, ST_FSEND, ST_FWAIT, ST_REPLY
   } fsm_t;

   fsm_t              fsm;
   logic              cur_write;
   logic [NID_W-1:0]  cur_node;
   logic [ADDR_W-1:0] cur_addr;
   logic [DATA_W-1:0] cur_data;
   logic [NODES-1:0]  pend;
   logic [NID_W-1:0]  own;

   logic              own_any, pend_any;
   logic [NID_W-1:0]  own_idx, pend_idx;
   logic [NODES-1:0]  p_bit, cur_bit, own_bit, pend_bit, others;
   logic              req_fire, own_is_req;

   dir_first_set #(.N(NODES)) i_own_find (
      .mask(lk_shr), .any(own_any), .idx(own_idx)
   );
   dir_first_set #(.N(NODES)) i_inv_find (
      .mask(pend), .any(pend_any), .idx(pend_idx)
   );

   assign p_bit      = NODES'(1) << req_node;
   assign cur_bit    = NODES'(1) << cur_node;
   assign own_bit    = NODES'(1) << own;
   assign pend_bit   = NODES'(1) << pend_idx;
   assign others     = lk_shr & ~p_bit;
   assign req_fire   = req_valid && (fsm == ST_IDLE);
   assign own_is_req = own_any && (own_idx == req_node);

   // Directory and storage updates
   always_comb begin
      dir_we     = 1'b0;
      dir_waddr  = cur_addr;
      dir_wstate = lk_state;
      dir_wshr   = lk_shr;
      mem_we     = 1'b0;
      mem_waddr  = cur_addr;
      mem_wdata  = rsp_data;
      if (req_fire) begin
         dir_waddr = req_addr;
         mem_waddr = req_addr;
         mem_wdata = req_data;
         unique case (req_kind)
            RQ_READ: begin
               if (lk_state == BLK_UNC) begin
                  dir_we = 1'b1; dir_wstate = BLK_SHR; dir_wshr = p_bit;
               end else if (lk_state == BLK_SHR) begin
                  dir_we = 1'b1; dir_wstate = BLK_SHR; dir_wshr = lk_shr | p_bit;
               end
            end
            RQ_WRITE: begin
               if (lk_state != BLK_EXC) begin
                  dir_we = 1'b1; dir_wstate = BLK_EXC; dir_wshr = p_bit;
               end
            end
            RQ_WBACK: begin
               if ((lk_state == BLK_EXC) && (lk_shr == p_bit)) begin
                  dir_we = 1'b1; dir_wstate = BLK_UNC; dir_wshr = '0;
                  mem_we = 1'b1;
               end
            end
            default: ;
         endcase
      end else if ((fsm == ST_FWAIT) && rsp_valid) begin
         dir_we = 1'b1;
         if (cur_write) begin
            dir_wstate = BLK_EXC;
            dir_wshr   = cur_bit;
         end else begin
            dir_wstate = BLK_SHR;
            dir_wshr   = cur_bit | own_bit;
            mem_we     = 1'b1;
         end
      end
   end

   // Sequencing of one request
   always_ff @(posedge clk) begin
      if (!rst_n) begin
         fsm       <= ST_IDLE;
         cur_write <= 1'b0;
         cur_node  <= '0;
         cur_addr  <= '0;
         cur_data  <= '0;
         pend      <= '0;
         own       <= '0;
      end else begin
         unique case (fsm)
            ST_IDLE: if (req_fire) begin
               cur_node  <= req_node;
               cur_addr  <= req_addr;
               cur_write <= (req_kind == RQ_WRITE);
               cur_data  <= lk_data;
               own       <= own_idx;
               if (req_kind == RQ_READ) begin
                  fsm <= (lk_state == BLK_EXC && !own_is_req) ? ST_FSEND : ST_REPLY;
               end else if (req_kind == RQ_WRITE) begin
                  if (lk_state == BLK_SHR) begin
                     pend <= others;
                     fsm  <= (others != '0) ? ST_INV : ST_REPLY;
                  end else if (lk_state == BLK_EXC && !own_is_req) begin
                     fsm <= ST_FSEND;
                  end else begin
                     fsm <= ST_REPLY;
                  end
               end
            end
            ST_INV: if (out_ready) begin
               pend <= pend & ~pend_bit;
               if ((pend & ~pend_bit) == '0) fsm <= ST_REPLY;
            end
            ST_FSEND: if (out_ready) fsm <= ST_FWAIT;
            ST_FWAIT: if (rsp_valid) begin
               cur_data <= rsp_data;
               fsm      <= ST_REPLY;
            end
            ST_REPLY: if (out_ready) fsm <= ST_IDLE;
            default: fsm <= ST_IDLE;
         endcase
      end
   end

   always_comb begin
      req_ready = (fsm == ST_IDLE);
      rsp_ready = (fsm == ST_FWAIT);
      out_valid = (fsm == ST_INV) || (fsm == ST_FSEND) || (fsm == ST_REPLY);
      out_addr  = cur_addr;
      out_data  = cur_data;
      out_kind  = MS_REPLY;
      out_node  = cur_node;
      if (fsm == ST_INV) begin
         out_kind = MS_INVAL;
         out_node = pend_idx;
      end else if (fsm == ST_FSEND || fsm == ST_FWAIT) begin
         out_kind = cur_write ? MS_FINV : MS_FETCH;
         out_node = own;
      end
      busy_node = cur_node;
   end

   logic unused_ok;
   assign unused_ok = pend_any;
endmodule

// File: rtl/dir_home_ctrl.sv
module dir_home_ctrl
   import dir_pkg::*;
#(
   parameter int NODES  = 4,
   parameter int ADDR_W = 4,
   parameter int DATA_W = 16,
   localparam int NID_W = $clog2(NODES)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              req_valid,
   output logic              req_ready,
   input  logic [1:0]        req_kind,
   input  logic [NID_W-1:0]  req_node,
   input  logic [ADDR_W-1:0] req_addr,
   input  logic [DATA_W-1:0] req_data,
   output logic              out_valid,
   input  logic              out_ready,
   output logic [1:0]        out_kind,
   output logic [NID_W-1:0]  out_node,
   output logic [ADDR_W-1:0] out_addr,
   output logic [DATA_W-1:0] out_data,
   input  logic              rsp_valid,
   output logic              rsp_ready,
   input  logic [DATA_W-1:0] rsp_data,
   input  logic [ADDR_W-1:0] probe_addr,
   output logic [1:0]        probe_state,
   output logic [NODES-1:0]  probe_sharers,
   output logic [DATA_W-1:0] probe_data
);
   if (NODES < 4 || NODES > 8 || (NODES & (NODES - 1)) != 0) begin : g_bad_nodes
      $error("NODES must be 4 or 8");
   end
   if (ADDR_W < 1 || ADDR_W > 8) begin : g_bad_addr
      $error("ADDR_W out of range");
   end
   if (DATA_W < 1) begin : g_bad_data
      $error("DATA_W must be positive");
   end

   blk_state_t        lk_state, pb_state;
   logic [NODES-1:0]  lk_shr;
   logic [DATA_W-1:0] lk_data;
   logic              dir_we, mem_we;
   logic [ADDR_W-1:0] dir_waddr, mem_waddr;
   blk_state_t        dir_wstate;
   logic [NODES-1:0]  dir_wshr;
   logic [DATA_W-1:0] mem_wdata;
   logic [NID_W-1:0]  busy_node;

   dir_store #(.NODES(NODES), .ADDR_W(ADDR_W), .DATA_W(DATA_W)) i_store (
      .clk(clk), .rst_n(rst_n),
      .ra_addr(req_addr), .ra_state(lk_state), .ra_shr(lk_shr), .ra_data(lk_data),
      .rb_addr(probe_addr), .rb_state(pb_state), .rb_shr(probe_sharers), .rb_data(probe_data),
      .dir_we(dir_we), .dir_waddr(dir_waddr), .dir_wstate(dir_wstate), .dir_wshr(dir_wshr),
      .mem_we(mem_we), .mem_waddr(mem_waddr), .mem_wdata(mem_wdata)
   );

   dir_engine #(.NODES(NODES), .ADDR_W(ADDR_W), .DATA_W(DATA_W)) i_engine (
      .clk(clk), .rst_n(rst_n),
      .req_valid(req_valid), .req_ready(req_ready), .req_kind(req_kind),
      .req_node(req_node), .req_addr(req_addr), .req_data(req_data),
      .out_valid(out_valid), .out_ready(out_ready), .out_kind(out_kind),
      .out_node(out_node), .out_addr(out_addr), .out_data(out_data),
      .rsp_valid(rsp_valid), .rsp_ready(rsp_ready), .rsp_data(rsp_data),
      .lk_state(lk_state), .lk_shr(lk_shr), .lk_data(lk_data),
      .dir_we(dir_we), .dir_waddr(dir_waddr), .dir_wstate(dir_wstate), .dir_wshr(dir_wshr),
      .mem_we(mem_we), .mem_waddr(mem_waddr), .mem_wdata(mem_wdata),
      .busy_node(busy_node)
   );

   assign probe_state = pb_state;
endmodule

// File: rtl/dir_home_chk.sv
module dir_home_chk #(
   parameter int NODES  = 4,
   parameter int ADDR_W = 4,
   parameter int DATA_W = 16,
   localparam int NID_W = $clog2(NODES)
) (
   input logic              clk,
   input logic              rst_n,
   input logic              req_ready,
   input logic              out_valid,
   input logic              out_ready,
   input logic [1:0]        out_kind,
   input logic [NID_W-1:0]  out_node,
   input logic [ADDR_W-1:0] out_addr,
   input logic [DATA_W-1:0] out_data,
   input logic              rsp_ready,
   input logic [NID_W-1:0]  busy_node,
   input logic [1:0]        probe_state,
   input logic [NODES-1:0]  probe_sharers
);
   assert_msg_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (out_valid && !out_ready) |=> (out_valid && $stable(out_kind) && $stable(out_node)
                                     && $stable(out_addr) && $stable(out_data)));

   assert_single_job_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (out_valid || rsp_ready) |-> !req_ready);

   assert_no_self_demand_R11: assert property (@(posedge clk) disable iff (!rst_n)
      (out_valid && out_kind != 2'd3) |-> (out_node != busy_node));

   assert_wait_quiet_R6: assert property (@(posedge clk) disable iff (!rst_n)
      rsp_ready |-> !out_valid);

   assert_excl_single_R10: assert property (@(posedge clk) disable iff (!rst_n)
      (probe_state == 2'd2) |-> ($countones(probe_sharers) == 1));

   assert_shared_some_R10: assert property (@(posedge clk) disable iff (!rst_n)
      (probe_state == 2'd1) |-> (probe_sharers != '0));

   assert_uncached_none_R10: assert property (@(posedge clk) disable iff (!rst_n)
      (probe_state == 2'd0) |-> (probe_sharers == '0));

   assert_state_code_R2: assert property (@(posedge clk) disable iff (!rst_n)
      probe_state != 2'd3);
endmodule

bind dir_home_ctrl dir_home_chk #(.NODES(NODES), .ADDR_W(ADDR_W), .DATA_W(DATA_W)) i_chk (
   .clk(clk), .rst_n(rst_n), .req_ready(req_ready), .out_valid(out_valid),
   .out_ready(out_ready), .out_kind(out_kind), .out_node(out_node),
   .out_addr(out_addr), .out_data(out_data), .rsp_ready(rsp_ready),
   .busy_node(busy_node), .probe_state(probe_state), .probe_sharers(probe_sharers)
);

// File: tb/test_dir_home_ctrl.sv
`timescale 1ns/1ps
module test_dir_home_ctrl;
   localparam int NODES = 4;
   localparam int AW    = 4;
   localparam int DW    = 16;
   localparam int NB    = 1 << AW;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          req_valid = 1'b0;
   logic          req_ready;
   logic [1:0]    req_kind = '0;
   logic [1:0]    req_node = '0;
   logic [AW-1:0] req_addr = '0;
   logic [DW-1:0] req_data = '0;
   logic          out_valid;
   logic          out_ready = 1'b0;
   logic [1:0]    out_kind;
   logic [1:0]    out_node;
   logic [AW-1:0] out_addr;
   logic [DW-1:0] out_data;
   logic          rsp_valid = 1'b0;
   logic          rsp_ready;
   logic [DW-1:0] rsp_data = '0;
   logic [AW-1:0] probe_addr = '0;
   logic [1:0]    probe_state;
   logic [3:0]    probe_sharers;
   logic [DW-1:0] probe_data;

   dir_home_ctrl #(.NODES(NODES), .ADDR_W(AW), .DATA_W(DW)) i_dir_home_ctrl (
      .clk(clk), .rst_n(rst_n),
      .req_valid(req_valid), .req_ready(req_ready), .req_kind(req_kind),
      .req_node(req_node), .req_addr(req_addr), .req_data(req_data),
      .out_valid(out_valid), .out_ready(out_ready), .out_kind(out_kind),
      .out_node(out_node), .out_addr(out_addr), .out_data(out_data),
      .rsp_valid(rsp_valid), .rsp_ready(rsp_ready), .rsp_data(rsp_data),
      .probe_addr(probe_addr), .probe_state(probe_state),
      .probe_sharers(probe_sharers), .probe_data(probe_data)
   );

   always #2 clk = ~clk;

   int checks = 0;
   int failures = 0;
   int cycles = 0;

   // stimulus table: {kind, node, addr, data}
   localparam int NV = 16;
   localparam logic [23:0] VEC [NV] = '{
      {2'd0, 2'd0, 4'd1, 16'h0000}, {2'd0, 2'd2, 4'd1, 16'h0000},
      {2'd0, 2'd3, 4'd1, 16'h0000}, {2'd1, 2'd2, 4'd1, 16'h1111},
      {2'd0, 2'd1, 4'd1, 16'h0000}, {2'd1, 2'd1, 4'd1, 16'h2222},
      {2'd1, 2'd3, 4'd1, 16'h3333}, {2'd2, 2'd0, 4'd1, 16'hDEAD},
      {2'd0, 2'd3, 4'd1, 16'h0000}, {2'd2, 2'd3, 4'd1, 16'h4444},
      {2'd2, 2'd1, 4'd1, 16'h5555}, {2'd1, 2'd0, 4'd2, 16'h6666},
      {2'd0, 2'd0, 4'd3, 16'h0000}, {2'd1, 2'd0, 4'd3, 16'h7777},
      {2'd0, 2'd1, 4'd2, 16'h0000}, {2'd0, 2'd2, 4'd1, 16'h0000}
   };

   // reference model
   int            m_st [NB];
   logic [3:0]    m_sh [NB];
   logic [DW-1:0] m_mem [NB];
   logic [DW-1:0] m_ov [NB];
   int            e_n;
   logic [1:0]    e_kind [8];
   logic [1:0]    e_node [8];
   logic [DW-1:0] e_data [8];
   logic [DW-1:0] fetch_val;
   string         tag;
   logic [15:0]   lfsr = 16'hACE1;

   task automatic chk(input logic ok, input string t, input string what,
                      input longint act, input longint exp);
      checks++;
      if (!ok) begin
         failures++;
         $display("FAIL %s %s actual=%0h expected=%0h", t, what, act, exp);
      end
   endtask

   task automatic push(input logic [1:0] k, input logic [1:0] n, input logic [DW-1:0] d);
      e_kind[e_n] = k; e_node[e_n] = n; e_data[e_n] = d; e_n++;
   endtask

   task automatic model(input logic [1:0] k, input logic [1:0] n,
                        input logic [AW-1:0] a, input logic [DW-1:0] d);
      logic [3:0] pb = 4'b1 << n;
      int own = 0;
      for (int i = 3; i >= 0; i--) if (m_sh[a][i]) own = i;
      e_n = 0;
      if (k == 2'd2) begin
         tag = "R8";
         if (m_st[a] == 2 && m_sh[a] == pb) begin
            m_mem[a] = d; m_st[a] = 0; m_sh[a] = 4'b0;
         end
      end else if (m_st[a] == 2 && own == int'(n)) begin
         tag = "R11";
         push(2'd3, n, m_mem[a]);
         if (k == 2'd1) m_ov[a] = d;
      end else if (k == 2'd0) begin
         if (m_st[a] == 0) begin
            tag = "R3"; push(2'd3, n, m_mem[a]); m_st[a] = 1; m_sh[a] = pb;
         end else if (m_st[a] == 1) begin
            tag = "R4"; push(2'd3, n, m_mem[a]); m_sh[a] = m_sh[a] | pb;
         end else begin
            tag = "R6"; fetch_val = m_ov[a];
            push(2'd1, 2'(own), 16'h0); push(2'd3, n, m_ov[a]);
            m_mem[a] = m_ov[a]; m_st[a] = 1; m_sh[a] = m_sh[a] | pb;
         end
      end else begin
         if (m_st[a] == 0) begin
            tag = "R3"; push(2'd3, n, m_mem[a]);
         end else if (m_st[a] == 1) begin
            tag = "R5";
            for (int i = 0; i < 4; i++)
               if (m_sh[a][i] && i != int'(n)) push(2'd0, 2'(i), 16'h0);
            push(2'd3, n, m_mem[a]);
         end else begin
            tag = "R7"; fetch_val = m_ov[a];
            push(2'd2, 2'(own), 16'h0); push(2'd3, n, m_ov[a]);
         end
         m_st[a] = 2; m_sh[a] = pb; m_ov[a] = d;
      end
   endtask

   task automatic run_req(input logic [1:0] k, input logic [1:0] n,
                          input logic [AW-1:0] a, input logic [DW-1:0] d,
                          input logic stall_en);
      int got = 0;
      logic stalled = 1'b0;
      logic holding = 1'b0;
      logic rsp_pend = 1'b0;
      logic done = 1'b0;
      logic [1:0] h_kind, h_node;
      logic [AW-1:0] h_addr;
      logic [DW-1:0] h_data;
      model(k, n, a, d);
      @(negedge clk);
      req_valid = 1'b1; req_kind = k; req_node = n; req_addr = a; req_data = d;
      @(negedge clk);
      req_valid = 1'b0;
      for (int g = 0; g < 40 && !done; g++) begin
         out_ready = 1'b0;
         rsp_valid = 1'b0;
         if (holding) begin
            chk(out_valid && out_kind == h_kind && out_node == h_node &&
                out_addr == h_addr && out_data == h_data, "R9", "held message",
                {out_kind, out_node, out_data}, {h_kind, h_node, h_data});
            holding = 1'b0;
         end
         if (req_ready) begin
            done = 1'b1;
         end else if (out_valid) begin
            lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
            if (stall_en && !stalled && lfsr[0]) begin
               stalled = 1'b1; holding = 1'b1;
               h_kind = out_kind; h_node = out_node; h_addr = out_addr; h_data = out_data;
            end else begin
               stalled = 1'b0;
               if (got < e_n) begin
                  chk(out_kind == e_kind[got], "R2", "message kind", out_kind, e_kind[got]);
                  chk(out_node == e_node[got], tag, "message node", out_node, e_node[got]);
                  chk(out_addr == a, tag, "message address", out_addr, a);
                  if (e_kind[got] == 2'd3)
                     chk(out_data == e_data[got], tag, "reply data", out_data, e_data[got]);
               end
               if (out_kind == 2'd1 || out_kind == 2'd2) rsp_pend = 1'b1;
               got++;
               out_ready = 1'b1;
            end
         end else if (rsp_ready && rsp_pend) begin
            rsp_valid = 1'b1; rsp_data = fetch_val; rsp_pend = 1'b0;
         end
         if (!done) @(negedge clk);
      end
      out_ready = 1'b0;
      rsp_valid = 1'b0;
      chk(done, tag, "request completion", done, 1);
      chk(got == e_n, tag, "message count", got, e_n);
      probe_addr = a;
      #0.5;
      chk(probe_state == 2'(m_st[a]), tag, "block state", probe_state, m_st[a]);
      chk(probe_sharers == m_sh[a], tag, "sharer vector", probe_sharers, m_sh[a]);
      chk(probe_data == m_mem[a], tag, "stored data", probe_data, m_mem[a]);
      chk((probe_state == 2'd0) == (probe_sharers == 4'b0), "R10", "state/sharer fit",
          probe_sharers, m_sh[a]);
   endtask

   always @(posedge clk) begin
      cycles++;
      if (cycles > 150000) begin
         failures++;
         checks++;
         $display("FAIL watchdog expired actual=%0d expected=%0d", cycles, 150000);
         $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
         $finish;
      end
   end

   initial begin
      for (int i = 0; i < NB; i++) begin
         m_st[i] = 0; m_sh[i] = 4'b0; m_mem[i] = '0; m_ov[i] = '0;
      end
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      // R1: reset state
      chk(req_ready, "R1", "req_ready after reset", req_ready, 1);
      chk(!out_valid, "R1", "out_valid after reset", out_valid, 0);
      for (int i = 0; i < NB; i += 5) begin
         probe_addr = AW'(i);
         #0.5;
         chk(probe_state == 2'd0 && probe_sharers == 4'b0 && probe_data == '0,
             "R1", "reset block", {probe_state, probe_sharers, probe_data}, 0);
      end
      // directed table
      for (int v = 0; v < NV; v++)
         run_req(VEC[v][23:22], VEC[v][21:20], VEC[v][19:16], VEC[v][15:0], 1'b0);
      // pseudo-random traffic with backpressure
      for (int r = 0; r < 120; r++) begin
         logic [1:0] k, n;
         logic [AW-1:0] a;
         lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
         a = AW'(4 + lfsr[1:0]);
         n = lfsr[3:2];
         k = (lfsr[6:4] < 3) ? 2'd0 : (lfsr[6:4] < 6) ? 2'd1 : 2'd2;
         if (k == 2'd2 && m_st[a] == 2 && lfsr[7])
            for (int i = 3; i >= 0; i--) if (m_sh[a][i]) n = 2'(i);
         run_req(k, n, a, lfsr ^ 16'h5A5A, 1'b1);
      end
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end
endmodule